// File: doc/BRIEF.md
# Parallel EEPROM Page-Write Controller

This block is the control logic of a byte-wide non-volatile memory, with the storage cells modelled as a register array. A host drives a chip-select strobe, a read strobe, a write strobe, an address and a data byte. The block samples all of these on a system clock. The address is split into a page (row) field and a byte-within-page (column) field of five bits, so each page holds 32 bytes. The default geometry has 64 rows. Eight row bits give the full 8192-byte array.

A write strobe latches its address and data. The host is then free to change both. The first write opens a load window. Later writes to the same row join the page buffer, and each accepted write restarts a load timer. When the timer expires without a new write, the block runs a self-timed programming phase of fixed length. At the end of that phase it copies every loaded byte of the page into the array in one step. Bytes that were not loaded keep their old contents. The host has no ready pin. From the first accepted write until programming ends, any read returns a status byte. Bit 7 of that byte is the complement of the last byte written, and bit 6 flips after each read. The host polls one of these bits to learn that the write has finished.

A power-good input masks every write strobe while supply power is not valid.

Top module: `pee_ctrl`

## Requirements
- R1: The address is {row, column}, with the column in the low COL_W = 5 bits and the row in the upper ROW_W bits. The default ROW_W is 6, and ROW_W = 8 gives 8192 bytes. Reads and writes address the byte at that location.
- R2: A write is captured in the clock cycle after the write strobe `wr_n` is seen rising while `sel_n` is low, `rd_n` is high and `pwr_good` is high. Address and data are taken as sampled at that rising edge, so the host may change them afterwards.
- R3: Each accepted write restarts the load timer. Loading ends, and programming begins, after LOAD_CYC clock cycles with no accepted write.
- R4: Programming lasts PROG_CYC cycles. At its end, all loaded bytes of the page are written to the array at once and the block returns to idle. It counts as busy from the first accepted write until then.
- R5: Column slots that were not loaded during a load window leave their array bytes unchanged.
- R6: During a load window, a write whose row differs from the row of the first write is dropped. It changes neither the array nor the last-written byte.
- R7: Writes attempted while programming are ignored. They do not start a new window, and they do not change the array or the last-written byte.
- R8: While `pwr_good` is low, write strobes are ignored and the block stays idle.
- R9: A read while busy returns, in bit 7, the complement of bit 7 of the last accepted byte, and in bits 5..0, bits 5..0 of that byte.
- R10: Bit 6 of a busy read is the toggle bit. It is 0 after reset and inverts each time a read (strobes `sel_n` and `rd_n` low) ends while busy.
- R11: `dout_en` is high exactly when, one clock earlier, `sel_n` and `rd_n` were low and `wr_n` was high. While idle, such a read returns the array byte at the address.
- R12: After reset, the block is idle with `dout_en` low and the toggle bit at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supply valid; low masks all writes |
| sel_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Output enable (read strobe), active low |
| wr_n | input | 1 | Write strobe, active low, captured on its rising edge |
| addr | input | ROW_W+COL_W | Byte address {row, column} |
| din | input | 8 | Write data from the host |
| dout | output | 8 | Read data or busy status |
| dout_en | output | 1 | Drive enable for the host data bus |

## Verification
Some rules hold on every cycle, and the assertions check them all the time. No byte is accepted while programming or while power was low. Every accepted byte inside a window matches the window's row. The page buffer is empty whenever the sequencer is idle. A commit happens only at the end of programming. The bus is driven only after a valid read strobe. Other behaviours need the bench's write-then-read scenarios, because only they can show them. These include the restart of the load timer, the length of the programming phase, slots left untouched by a partial page, dropped and ignored writes leaving data intact, and the exact polling and toggle values seen across successive reads.

// File: rtl/pee_pkg.sv
package pee_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_LOAD = 2'd1,
    SEQ_PROG = 2'd2
  } seq_state_t;
endpackage

// File: rtl/pee_strobe.sv
// Samples the host strobes once on clk and derives write and read events.
module pee_strobe #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              sel_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic              wr_evt,
  output logic              rd_act,
  output logic              rd_end,
  output logic [ADDR_W-1:0] addr_q,
  output logic [7:0]        din_q
);
  logic sel_q, rd_q, wr_q, wr_qq, pwr_q, rd_act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= 1'b1;
      rd_q     <= 1'b1;
      wr_q     <= 1'b1;
      wr_qq    <= 1'b1;
      pwr_q    <= 1'b0;
      rd_act_q <= 1'b0;
      addr_q   <= '0;
      din_q    <= '0;
    end else begin
      sel_q    <= sel_n;
      rd_q     <= rd_n;
      wr_q     <= wr_n;
      wr_qq    <= wr_q;
      pwr_q    <= pwr_good;
      rd_act_q <= rd_act;
      addr_q   <= addr;
      din_q    <= din;
    end
  end

  assign wr_evt = wr_q & ~wr_qq & ~sel_q & rd_q & pwr_q;
  assign rd_act = ~sel_q & ~rd_q & wr_q;
  assign rd_end = rd_act_q & ~rd_act;
endmodule

// File: rtl/pee_seq.sv
// Load-window timer and self-timed programming sequencer.
module pee_seq
  import pee_pkg::*;
#(
  parameter int LOAD_CYC = 100,
  parameter int PROG_CYC = 400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_evt,
  input  logic       row_hit,
  output seq_state_t state,
  output logic       load_en,
  output logic       commit
);
  localparam int MAXC  = (LOAD_CYC > PROG_CYC) ? LOAD_CYC : PROG_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  seq_state_t st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    load_en = 1'b0;
    commit  = 1'b0;
    unique case (st_q)
      SEQ_IDLE: begin
        if (wr_evt) begin
          load_en = 1'b1;
          st_d    = SEQ_LOAD;
          cnt_d   = '0;
        end
      end
      SEQ_LOAD: begin
        if (wr_evt && row_hit) begin
          load_en = 1'b1;
          cnt_d   = '0;
        end else if (cnt_q == CNT_W'(LOAD_CYC - 1)) begin
          st_d  = SEQ_PROG;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SEQ_PROG: begin
        if (cnt_q == CNT_W'(PROG_CYC - 1)) begin
          commit = 1'b1;
          st_d   = SEQ_IDLE;
          cnt_d  = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        st_d  = SEQ_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign state = st_q;
endmodule

// File: rtl/pee_pagebuf.sv
// Page buffer: 2**COL_W byte slots with load flags, page row and last byte.
module pee_pagebuf #(
  parameter int ROW_W = 6,
  parameter int COL_W = 5
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           load_en,
  input  logic                           first,
  input  logic                           clear,
  input  logic [ROW_W+COL_W-1:0]         wr_addr,
  input  logic [7:0]                     wr_data,
  output logic                           row_hit,
  output logic [ROW_W-1:0]               row_q,
  output logic [(1<<COL_W)-1:0][7:0]     pg_q,
  output logic [(1<<COL_W)-1:0]          vld_q,
  output logic [7:0]                     last_q
);
  localparam int PAGE = 1 << COL_W;

  logic [PAGE-1:0][7:0] pg_d;
  logic [PAGE-1:0]      vld_d;
  logic [ROW_W-1:0]     row_d;
  logic [7:0]           last_d;
  logic [ROW_W-1:0]     wr_row;
  logic [COL_W-1:0]     wr_col;

  assign wr_row  = wr_addr[ROW_W+COL_W-1:COL_W];
  assign wr_col  = wr_addr[COL_W-1:0];
  assign row_hit = (wr_row == row_q);

  always_comb begin
    pg_d   = pg_q;
    vld_d  = vld_q;
    row_d  = row_q;
    last_d = last_q;
    if (clear) vld_d = '0;
    if (load_en) begin
      if (first) row_d = wr_row;
      pg_d[wr_col]  = wr_data;
      vld_d[wr_col] = 1'b1;
      last_d        = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_q   <= '0;
      vld_q  <= '0;
      row_q  <= '0;
      last_q <= '0;
    end else begin
      pg_q   <= pg_d;
      vld_q  <= vld_d;
      row_q  <= row_d;
      last_q <= last_d;
    end
  end
endmodule

// File: rtl/pee_ctrl.sv
// Top: strobe sampling, page buffer, sequencer, cell array and read mux.
module pee_ctrl
  import pee_pkg::*;
#(
  parameter int ROW_W    = 6,
  parameter int COL_W    = 5,
  parameter int LOAD_CYC = 100,
  parameter int PROG_CYC = 400
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pwr_good,
  input  logic                   sel_n,
  input  logic                   rd_n,
  input  logic                   wr_n,
  input  logic [ROW_W+COL_W-1:0] addr,
  input  logic [7:0]             din,
  output logic [7:0]             dout,
  output logic                   dout_en
);
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int PAGE   = 1 << COL_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              wr_evt, rd_act, rd_end;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        din_q;
  seq_state_t        seq_st;
  logic              load_en, commit, row_hit, busy;
  logic [ROW_W-1:0]  row_q;
  logic [PAGE-1:0][7:0] pg_q;
  logic [PAGE-1:0]   vld;
  logic [7:0]        last_q;
  logic              tog_q, tog_d;
  logic [7:0]        mem [DEPTH];

  pee_strobe #(.ADDR_W(ADDR_W)) i_strobe (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .sel_n(sel_n),
    .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .din(din),
    .wr_evt(wr_evt), .rd_act(rd_act), .rd_end(rd_end),
    .addr_q(addr_q), .din_q(din_q)
  );

  pee_seq #(.LOAD_CYC(LOAD_CYC), .PROG_CYC(PROG_CYC)) i_seq (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .row_hit(row_hit),
    .state(seq_st), .load_en(load_en), .commit(commit)
  );

  pee_pagebuf #(.ROW_W(ROW_W), .COL_W(COL_W)) i_pagebuf (
    .clk(clk), .rst_n(rst_n), .load_en(load_en),
    .first(seq_st == SEQ_IDLE), .clear(commit),
    .wr_addr(addr_q), .wr_data(din_q), .row_hit(row_hit),
    .row_q(row_q), .pg_q(pg_q), .vld_q(vld), .last_q(last_q)
  );

  // Cell array: written only at the end of programming, loaded slots only.
  always_ff @(posedge clk) begin
    if (commit) begin
      for (int i = 0; i < PAGE; i++) begin
        if (vld[i]) mem[{row_q, COL_W'(i)}] <= pg_q[i];
      end
    end
  end

  assign busy = (seq_st != SEQ_IDLE);

  always_comb begin
    tog_d = tog_q;
    if (busy && rd_end) tog_d = ~tog_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= tog_d;
  end

  assign dout    = busy ? {~last_q[7], tog_q, last_q[5:0]} : mem[addr_q];
  assign dout_en = rd_act;
endmodule

// File: rtl/pee_chk.sv
module pee_chk
  import pee_pkg::*;
#(
  parameter int PAGE = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pwr_good,
  input logic            sel_n,
  input logic            rd_n,
  input logic            wr_n,
  input logic            dout_en,
  input seq_state_t      state,
  input logic            load_en,
  input logic            commit,
  input logic            row_hit,
  input logic [PAGE-1:0] vld
);
  // R7
  prog_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_PROG) |-> !load_en);
  // R6
  row_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && state == SEQ_LOAD) |-> row_hit);
  // R4
  commit_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (state == SEQ_PROG));
  // R4
  commit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (state == SEQ_IDLE));
  // R5
  idle_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_IDLE) |-> (vld == '0));
  // R8
  pwr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pwr_good) |-> !load_en);
  // R11
  rd_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> (!$past(sel_n) && !$past(rd_n) && $past(wr_n)));
endmodule

bind pee_ctrl pee_chk #(.PAGE(PAGE)) i_chk (
  .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .sel_n(sel_n),
  .rd_n(rd_n), .wr_n(wr_n), .dout_en(dout_en), .state(seq_st),
  .load_en(load_en), .commit(commit), .row_hit(row_hit), .vld(vld)
);

// File: tb/test_pee_ctrl.sv
module test_pee_ctrl;
  localparam int CLK_P    = 10;
  localparam int ROW_W    = 6;
  localparam int COL_W    = 5;
  localparam int LOAD_CYC = 100;
  localparam int PROG_CYC = 400;
  localparam int AW       = ROW_W + COL_W;

  typedef struct {
    logic [7:0] val;
    string      tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pwr_good = 1'b1;
  logic          sel_n = 1'b1;
  logic          rd_n = 1'b1;
  logic          wr_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = '0;
  logic [7:0]    dout;
  logic          dout_en;

  int   n_chk = 0;
  int   n_err = 0;
  bit   done = 1'b0;
  exp_t sb[$];
  event smp_ev;
  logic       tog_m = 1'b0;
  logic [7:0] last_m = '0;
  logic [7:0] r3 [32];

  pee_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .LOAD_CYC(LOAD_CYC), .PROG_CYC(PROG_CYC))
    i_pee_ctrl (.clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .sel_n(sel_n),
                .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .din(din),
                .dout(dout), .dout_en(dout_en));

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard whenever the driver marks a sample point.
  always @(smp_ev) begin
    exp_t e;
    e = sb.pop_front();
    check({7'd0, dout_en}, 8'd1, {e.tag, " R11 dout_en"});
    check(dout, e.val, e.tag);
  end

  function automatic logic [AW-1:0] adr(input int row, input int col);
    return {ROW_W'(row), COL_W'(col)};
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; din = d; sel_n = 1'b0; rd_n = 1'b1; wr_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
    addr = ~a; din = ~d;   // host changes bus after the strobe (R2)
    @(negedge clk);
    sel_n = 1'b1;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    addr = a; sel_n = 1'b0; rd_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    sb.push_back('{exp, tag});
    -> smp_ev;
    @(negedge clk);
    sel_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic busy_rd(input string tag);
    rd('0, {~last_m[7], tog_m, last_m[5:0]}, tag);
    tog_m = ~tog_m;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    if (!done) begin
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    idle(3);
    check({7'd0, dout_en}, 8'd0, "R12 dout_en low in reset");
    rst_n = 1'b1;
    idle(2);
    check({7'd0, dout_en}, 8'd0, "R12 dout_en low after reset");

    // Single byte, then polling/toggle from reset value 0.
    wr(adr(4, 0), 8'h5A); last_m = 8'h5A;
    busy_rd("R9 R10 R12 first busy read");
    idle(LOAD_CYC + PROG_CYC + 50);
    rd(adr(4, 0), 8'h5A, "R1 R2 single byte stored");

    // Full page on row 3.
    for (int i = 0; i < 32; i++) begin
      r3[i] = 8'(i * 9 + 3);
      wr(adr(3, i), r3[i]);
    end
    last_m = r3[31];
    busy_rd("R9 R10 busy read A");
    busy_rd("R9 R10 busy read B");
    idle(LOAD_CYC + PROG_CYC + 50);
    for (int i = 0; i < 32; i++) rd(adr(3, i), r3[i], "R4 full page");

    // Partial page with a foreign-row write in the window.
    wr(adr(3, 0), 8'hA0);
    wr(adr(3, 5), 8'hA5);
    wr(adr(4, 0), 8'hFF);
    wr(adr(3, 31), 8'h3F);
    last_m = 8'h3F; r3[0] = 8'hA0; r3[5] = 8'hA5; r3[31] = 8'h3F;
    busy_rd("R6 R9 last byte excludes dropped write");
    idle(LOAD_CYC + PROG_CYC + 50);
    for (int i = 0; i < 32; i++) rd(adr(3, i), r3[i], "R5 partial page");
    rd(adr(4, 0), 8'h5A, "R6 foreign row dropped");

    // Write during programming is ignored.
    wr(adr(3, 1), 8'h11); last_m = 8'h11; r3[1] = 8'h11;
    idle(LOAD_CYC + 50);
    wr(adr(3, 2), 8'h22);
    busy_rd("R7 last byte unchanged by ignored write");
    idle(PROG_CYC);
    rd(adr(3, 1), 8'h11, "R7 window byte stored");
    rd(adr(3, 2), r3[2], "R7 ignored write left array");
    rd(adr(3, 3), r3[3], "R7 no new window opened");

    // Power-good masks strobes.
    pwr_good = 1'b0;
    wr(adr(3, 3), 8'h33);
    pwr_good = 1'b1;
    rd(adr(3, 3), r3[3], "R8 masked write, still idle");

    // Load timer restarts; programming length.
    wr(adr(5, 10), 8'h6C);
    idle(LOAD_CYC - 20);
    wr(adr(5, 11), 8'h93); last_m = 8'h93;
    idle(LOAD_CYC + PROG_CYC - 45);
    busy_rd("R3 R4 still busy after timer restart");
    idle(80);
    rd(adr(5, 10), 8'h6C, "R3 first byte of window");
    rd(adr(5, 11), 8'h93, "R3 R4 second byte of window");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule